// File: doc/BRIEF.md
# Convergent Accumulator Rounding Unit

This block takes the wide result of a multiply-accumulate datapath and produces a shorter, rounded value for a destination register. It works in one of two sizes. In the narrow size, a 40-bit value is cut at the boundary between bit 15 and bit 16. In the wide size, a 72-bit value is cut at the boundary between bit 31 and bit 32. The bits above the cut are kept. The bits below the cut decide whether the kept part is incremented.

A single mode input selects the rounding style. Unbiased rounding sends an exact halfway value to the nearest even result. Biased rounding always sends a halfway value upward. The unit never writes back to the accumulator. It only delivers the rounded value on its result port.

The caller pulses a start strobe together with the operand, the size select and the mode. One clock later the result port carries the rounded value and the valid flag is high for that cycle. A small controller with two states tracks this:
- `ST_IDLE` means no result is being presented.
- `ST_EMIT` means the result port carries a value captured on the previous edge.

The controller has three transitions:
- `ST_IDLE` goes to `ST_EMIT` when the strobe is seen.
- `ST_EMIT` stays in `ST_EMIT` on a back-to-back strobe.
- `ST_EMIT` returns to `ST_IDLE` when no strobe arrives.

Top module: `rnd_conv_unit`

## Requirements
- R1: After reset, `res_vld_o` is 0 and `res_o` is all zeros.
- R2: A strobe on `go_i` at one rising edge makes `res_vld_o` high after that edge, with the rounded value on `res_o`. After an edge with no strobe, `res_vld_o` is 0 and `res_o` keeps its previous value.
- R3: With `wide_i` = 0, the result is `acc_i[39:16]` plus `acc_i[15]`, modulo 2^24, placed in `res_o[23:0]`. `res_o[39:24]` is 0. `acc_i[71:40]` has no effect on the result.
- R4: With `wide_i` = 1, the result is `acc_i[71:32]` plus `acc_i[31]`, modulo 2^40, placed in `res_o[39:0]`.
- R5: With `biased_i` = 0 and `wide_i` = 0, an exact midpoint is `acc_i[15]` = 1 with `acc_i[14:0]` all zero. For a midpoint, bit 0 of the result is forced to 0 after the increment, so the tie goes to the even value.
- R6: With `biased_i` = 0 and `wide_i` = 1, an exact midpoint is `acc_i[31]` = 1 with `acc_i[30:0]` all zero. For a midpoint, bit 0 of the result is forced to 0 after the increment.
- R7: With `biased_i` = 1, an exact midpoint in either size always rounds upward: the kept part plus one.
- R8: In both modes, a discarded part below the midpoint truncates. A discarded part above the midpoint rounds upward.
- R9: A carry out of the top kept bit wraps silently. A kept part of all ones that rounds up gives all zeros, and no saturation is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 72 | Accumulator operand. The narrow size uses bits 39..0 |
| wide_i | input | 1 | Size select: 0 = 40-bit operand cut at bit 16, 1 = 72-bit operand cut at bit 32 |
| biased_i | input | 1 | Rounding style: 0 = unbiased (ties to even), 1 = biased (ties up) |
| go_i | input | 1 | Round strobe, one cycle per operation |
| res_o | output | 40 | Rounded kept part. The narrow size fills bits 23..0 |
| res_vld_o | output | 1 | High for the cycle after a strobe |

## Verification
Uniformly random operands almost never hit an exact midpoint. An exact midpoint needs 15 or 31 specific zero bits under a set half bit. Without help, the tie-to-even path and its difference from biased rounding would go unexercised.

The stimulus therefore builds operands from chosen parts:
- a random kept part with its parity controlled;
- a discarded part forced to exactly half, to half plus one, or to half minus one.

Each of these is sent in both sizes and both modes. The all-ones kept part with a midpoint or above-midpoint fraction is added on top, to reach the wrap case.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    localparam int NARROW_W_DEF   = 40;
    localparam int NARROW_CUT_DEF = 16;
    localparam int WIDE_W_DEF     = 72;
    localparam int WIDE_CUT_DEF   = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } rnd_state_e;

    typedef enum logic {
        RND_UNBIASED = 1'b0,
        RND_BIASED   = 1'b1
    } rnd_mode_e;

endpackage

// File: rtl/rnd_tie_detect.sv
module rnd_tie_detect #(
    parameter int CUT = 16
) (
    input  logic [CUT-1:0] frac_i,
    output logic           half_o,
    output logic           tie_o
);

    // The half bit sits just below the cut; the tie needs everything under it clear.
    logic below_zero;

    generate
        if (CUT > 1) begin : g_below
            assign below_zero = ~|frac_i[CUT-2:0];
        end else begin : g_none
            assign below_zero = 1'b1;
        end
    endgenerate

    assign half_o = frac_i[CUT-1];
    assign tie_o  = frac_i[CUT-1] & below_zero;

endmodule

// File: rtl/rnd_lane.sv
module rnd_lane #(
    parameter int IN_W = 40,
    parameter int CUT  = 16
) (
    input  logic [IN_W-1:0]     val_i,
    input  logic                biased_i,
    output logic [IN_W-CUT-1:0] kept_o,
    output logic                tie_o
);

    localparam int KW = IN_W - CUT;

    logic          half;
    logic          tie;
    logic [KW-1:0] incr;

    rnd_tie_detect #(.CUT(CUT)) tie_i (
        .frac_i (val_i[CUT-1:0]),
        .half_o (half),
        .tie_o  (tie)
    );

    // Add the half bit into the kept part; any carry out of the top is dropped.
    assign incr = val_i[IN_W-1:CUT] + KW'(half);

    always_comb begin
        kept_o = incr;
        if (tie && !biased_i) begin
            kept_o[0] = 1'b0;
        end
    end

    assign tie_o = tie;

endmodule

// File: rtl/rnd_seq_fsm.sv
module rnd_seq_fsm
    import rnd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic go_i,
    output logic vld_o
);

    rnd_state_e state_q;
    rnd_state_e state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        vld_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go_i) state_d = ST_EMIT;
            end
            ST_EMIT: begin
                vld_o = 1'b1;
                if (!go_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_VLD_AFTER_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_i |=> vld_o); // R2

    AST_NO_VLD_WITHOUT_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !go_i |=> !vld_o); // R2

endmodule

// File: rtl/rnd_conv_unit.sv
module rnd_conv_unit
    import rnd_pkg::*;
#(
    parameter int NARROW_W   = NARROW_W_DEF,
    parameter int NARROW_CUT = NARROW_CUT_DEF,
    parameter int WIDE_W     = WIDE_W_DEF,
    parameter int WIDE_CUT   = WIDE_CUT_DEF,
    localparam int NK        = NARROW_W - NARROW_CUT,
    localparam int WK        = WIDE_W - WIDE_CUT
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WIDE_W-1:0] acc_i,
    input  logic              wide_i,
    input  logic              biased_i,
    input  logic              go_i,
    output logic [WK-1:0]     res_o,
    output logic              res_vld_o
);

    logic [NK-1:0] narrow_kept;
    logic [WK-1:0] wide_kept;
    logic          narrow_tie;
    logic          wide_tie;
    logic [WK-1:0] picked;

    rnd_lane #(.IN_W(NARROW_W), .CUT(NARROW_CUT)) narrow_lane_i (
        .val_i    (acc_i[NARROW_W-1:0]),
        .biased_i (biased_i),
        .kept_o   (narrow_kept),
        .tie_o    (narrow_tie)
    );

    rnd_lane #(.IN_W(WIDE_W), .CUT(WIDE_CUT)) wide_lane_i (
        .val_i    (acc_i),
        .biased_i (biased_i),
        .kept_o   (wide_kept),
        .tie_o    (wide_tie)
    );

    always_comb begin
        if (wide_i) begin
            picked = wide_kept;
        end else begin
            picked = WK'(narrow_kept);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_o <= '0;
        end else if (go_i) begin
            res_o <= picked;
        end
    end

    rnd_seq_fsm seq_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (go_i),
        .vld_o  (res_vld_o)
    );

    AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !go_i |=> $stable(res_o)); // R2

    AST_NARROW_TIE_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_i && !wide_i && !biased_i && narrow_tie |=> !res_o[0]); // R5

    AST_WIDE_TIE_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_i && wide_i && !biased_i && wide_tie |=> !res_o[0]); // R6

    AST_BIASED_TIE_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_i && !wide_i && biased_i && narrow_tie |=>
        res_o[NK-1:0] == NK'($past(acc_i[NARROW_W-1:NARROW_CUT]) + NK'(1))); // R7

    AST_BELOW_HALF_TRUNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_i && wide_i && !acc_i[WIDE_CUT-1] |=>
        res_o == $past(acc_i[WIDE_W-1:WIDE_CUT])); // R8

    generate
        if (WK > NK) begin : g_narrow_top
            AST_NARROW_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
                go_i && !wide_i |=> res_o[WK-1:NK] == '0); // R3
        end
    endgenerate

endmodule

// File: tb/rnd_conv_unit_tb_top.sv
`timescale 1ns/1ps
module rnd_conv_unit_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [71:0] acc_i = '0;
    logic        wide_i = 1'b0;
    logic        biased_i = 1'b0;
    logic        go_i = 1'b0;
    logic [39:0] res_o;
    logic        res_vld_o;

    int checks = 0;
    int fails  = 0;
    logic [39:0] exp_q[$];
    string       tag_q[$];
    logic [39:0] last_exp = '0;
    bit          done = 1'b0;

    always #2.5 clk_i = ~clk_i;

    rnd_conv_unit dut_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .acc_i     (acc_i),
        .wide_i    (wide_i),
        .biased_i  (biased_i),
        .go_i      (go_i),
        .res_o     (res_o),
        .res_vld_o (res_vld_o)
    );

    function automatic logic [39:0] ref_round(logic [71:0] a, logic w, logic b);
        int          cut;
        int          kw;
        logic [71:0] kept;
        logic [71:0] frac;
        logic [71:0] half;
        logic [71:0] msk;
        bit          up;
        cut  = w ? 32 : 16;
        kw   = w ? 40 : 24;
        if (!w) a = a & ((72'd1 << 40) - 72'd1);
        kept = a >> cut;
        frac = a & ((72'd1 << cut) - 72'd1);
        half = 72'd1 << (cut - 1);
        if (frac > half)       up = 1'b1;
        else if (frac < half)  up = 1'b0;
        else                   up = b ? 1'b1 : kept[0];
        msk  = (72'd1 << kw) - 72'd1;
        return 40'((kept + 72'(up)) & msk);
    endfunction

    task automatic check(string tag, logic [39:0] act, logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [71:0] a, logic w, logic b, string tag);
        @(negedge clk_i);
        acc_i = a; wide_i = w; biased_i = b; go_i = 1'b1;
        exp_q.push_back(ref_round(a, w, b));
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i);
            go_i = 1'b0;
            acc_i = {$urandom, $urandom, $urandom};
        end
    endtask

    // Scoreboard monitor
    always @(posedge clk_i) begin
        #1;
        if (rst_ni && res_vld_o) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2: actual valid=1 expected valid=0 (nothing pending)");
            end else begin
                last_exp = exp_q.pop_front();
                check(tag_q.pop_front(), res_o, last_exp);
            end
        end
    end

    function automatic logic [71:0] build(logic w, logic [39:0] kept, int kind);
        int          cut;
        logic [71:0] frac;
        logic [71:0] half;
        cut  = w ? 32 : 16;
        half = 72'd1 << (cut - 1);
        case (kind)
            0: frac = half;
            1: frac = half + 72'd1;
            default: frac = half - 72'd1;
        endcase
        if (w) return ({32'd0, kept} << 32) | frac;
        return ({$urandom, 40'd0} & ~((72'd1 << 40) - 72'd1)) | ({48'd0, kept[23:0]} << 16) | frac;
    endfunction

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk_i);
            cyc++;
            if (cyc > 100000) begin
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        check("R1 reset valid", {39'd0, res_vld_o}, 40'd0);
        check("R1 reset result", res_o, 40'd0);
        rst_ni = 1'b1;
        idle(2);

        // Hand-picked midpoints, both parities, both modes, both sizes
        drive(build(1'b0, 40'h000000_1234, 0), 1'b0, 1'b0, "R5 narrow tie even kept");
        drive(build(1'b0, 40'h000000_1235, 0), 1'b0, 1'b0, "R5 narrow tie odd kept");
        drive(build(1'b1, 40'h12_3456_7890, 0), 1'b1, 1'b0, "R6 wide tie even kept");
        drive(build(1'b1, 40'h12_3456_7891, 0), 1'b1, 1'b0, "R6 wide tie odd kept");
        drive(build(1'b0, 40'h000000_1234, 0), 1'b0, 1'b1, "R7 narrow tie biased");
        drive(build(1'b1, 40'h12_3456_7890, 0), 1'b1, 1'b1, "R7 wide tie biased");
        idle(1);
        drive(build(1'b0, 40'h000000_0777, 1), 1'b0, 1'b0, "R8 narrow above half");
        drive(build(1'b0, 40'h000000_0777, 2), 1'b0, 1'b1, "R8 narrow below half");
        drive(build(1'b1, 40'h00_0000_0777, 1), 1'b1, 1'b1, "R8 wide above half");
        drive(build(1'b1, 40'h00_0000_0777, 2), 1'b1, 1'b0, "R8 wide below half");
        drive(build(1'b0, 40'h000000_ffffff, 0), 1'b0, 1'b1, "R9 narrow wrap");
        drive(build(1'b1, 40'hff_ffff_ffff, 1), 1'b1, 1'b0, "R9 wide wrap");
        drive(build(1'b0, 40'h000000_ffffff, 0), 1'b0, 1'b0, "R9 narrow all-ones tie even");
        idle(2);

        // Idle cycles: valid low, result held
        @(negedge clk_i);
        check("R2 valid low without strobe", {39'd0, res_vld_o}, 40'd0);
        check("R2 result held", res_o, last_exp);

        // Random traffic with forced midpoints mixed in
        for (int i = 0; i < 400; i++) begin
            logic [71:0] a;
            logic        w;
            logic        b;
            a = {$urandom, $urandom, $urandom};
            w = 1'($urandom);
            b = 1'($urandom);
            if (($urandom % 3) == 0) a = build(w, {$urandom, $urandom}, int'($urandom % 3));
            drive(a, w, b, w ? "R4 wide random" : "R3 narrow random");
            if (($urandom % 4) == 0) idle(1);
        end
        idle(3);
        @(negedge clk_i);
        check("R2 valid low after traffic", {39'd0, res_vld_o}, 40'd0);
        check("R2 final result held", res_o, last_exp);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R2: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule